// File: doc/BRIEF.md
# Double-Precision to Signed 16-bit Integer Converter

This block takes a 64-bit binary floating-point operand and turns it into a 16-bit two's-complement integer, truncating toward zero. It sorts the operand into zero, subnormal, normal, infinity or not-a-number, aligns the significand of normal values by their exponent, and checks the result against the signed 16-bit range. Values that cannot be represented never wrap: they produce a defined saturated result and raise an invalid flag. Any fraction bits dropped by truncation raise an inexact flag instead.

The converter sits behind a valid strobe. Each accepted operand yields its integer and flags one clock later, with an output valid strobe that follows the input strobe by the same single cycle. When no operand is offered, the output register holds its last value. All field widths and the integer width are parameters, checked during elaboration.

Top module: `dtoi_conv`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock; result and flags load only on cycles where `in_valid` is high and otherwise hold their values.
- R2: An operand whose exponent field (bits 62:52) and fraction field (bits 51:0) are both zero gives 0 with both flags clear, whatever the sign bit (bit 63).
- R3: An operand with a zero exponent field and a nonzero fraction field (subnormal) gives 0 with `out_inexact` set and `out_invalid` clear.
- R4: A normal operand (exponent field neither all zeros nor all ones, bias 1023) with magnitude below 1.0 gives 0 with `out_inexact` set.
- R5: A normal operand whose truncated value lies in [-32768, 32767] gives that value rounded toward zero, `out_invalid` clear, and `out_inexact` set exactly when nonzero fraction bits were discarded.
- R6: A positive normal operand of 32768.0 or more gives 32767 with `out_invalid` set and `out_inexact` clear.
- R7: A negative operand in (-32769.0, -32768.0] gives -32768 without `out_invalid`; a negative normal operand of -32769.0 or below gives -32768 with `out_invalid` set and `out_inexact` clear.
- R8: An all-ones exponent field with a zero fraction (infinity) gives 32767 for sign 0 and -32768 for sign 1, with `out_invalid` set.
- R9: An all-ones exponent field with a nonzero fraction (not-a-number, either sign, quiet or signaling) gives 0 with `out_invalid` set.
- R10: `out_invalid` and `out_inexact` are never high together.
- R11: During reset `out_valid`, `out_int`, `out_invalid` and `out_inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 64 | Floating-point operand: sign, exponent, fraction |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | 16 | Two's-complement integer result |
| out_invalid | output | 1 | Operand not representable, infinity or not-a-number |
| out_inexact | output | 1 | Nonzero fraction bits discarded |

## Verification
The hardest corner is the asymmetric negative edge: operands whose integer part is exactly 32768 are legal only when negative, so the exponent-15 band must be driven with both signs and with and without a fraction tail. The bench reaches it with -32768.0, -32768.5 and -32769.0 against +32768.0 and 65535.5, so the positive overflow, the negative legal endpoint with inexact, and the first negative overflow all share one alignment distance. Every scenario task applies one operand per strobe and samples on the following falling edge.

// File: rtl/dtoi_pkg.sv
package dtoi_pkg;
   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUBN = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_NAN  = 3'd4
   } dtoi_cls_e;
endpackage

// File: rtl/dtoi_classify.sv
// Splits the exponent/fraction fields into a class and an unbiased exponent.
module dtoi_classify
   import dtoi_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W-1:0]         exp_f,
   input  logic [FRAC_W-1:0]        frac_f,
   output dtoi_cls_e                cls,
   output logic signed [EXP_W:0]    unb_exp
);
   localparam logic signed [EXP_W:0] BIAS_S = (EXP_W+1)'((1 << (EXP_W-1)) - 1);

   logic exp_ones;
   logic exp_zero;
   logic frac_nz;

   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign frac_nz  = |frac_f;

   always_comb begin
      if (exp_zero)      cls = frac_nz ? CLS_SUBN : CLS_ZERO;
      else if (exp_ones) cls = frac_nz ? CLS_NAN  : CLS_INF;
      else               cls = CLS_NORM;
   end

   assign unb_exp = $signed({1'b0, exp_f}) - BIAS_S;
endmodule

// File: rtl/dtoi_align.sv
// Shifts the significand right by (FRAC_W - e) and collects discarded bits.
module dtoi_align #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 16
) (
   input  logic [FRAC_W-1:0]        frac_f,
   input  logic signed [EXP_W:0]    unb_exp,
   output logic [INT_W-1:0]         mag,
   output logic                     too_big,
   output logic                     below_one,
   output logic                     sticky
);
   localparam int SH_W = $clog2(FRAC_W + 1);
   localparam logic [SH_W-1:0]      FRAC_SH = SH_W'(FRAC_W);
   localparam logic signed [EXP_W:0] INT_LIM = (EXP_W+1)'(INT_W);

   logic [FRAC_W:0]   sig;
   logic [SH_W-1:0]   e_small;
   logic [SH_W-1:0]   sh;
   logic [FRAC_W:0]   shifted;
   logic [FRAC_W-1:0] dropped;

   assign sig       = {1'b1, frac_f};
   assign below_one = unb_exp[EXP_W];
   assign too_big   = (unb_exp >= INT_LIM);
   assign e_small   = unb_exp[SH_W-1:0];
   assign sh        = FRAC_SH - e_small;
   assign shifted   = sig >> sh;
   assign mag       = shifted[INT_W-1:0];

   // one tap per fraction bit: discarded when its position is below the shift
   for (genvar i = 0; i < FRAC_W; i++) begin : g_drop
      assign dropped[i] = frac_f[i] & (SH_W'(i) < sh);
   end

   assign sticky = |dropped;
endmodule

// File: rtl/dtoi_range.sv
// Chooses the final integer and flags from class, magnitude and sign.
module dtoi_range
   import dtoi_pkg::*;
#(
   parameter int INT_W = 16
) (
   input  logic              sign,
   input  dtoi_cls_e         cls,
   input  logic [INT_W-1:0]  mag,
   input  logic              too_big,
   input  logic              below_one,
   input  logic              sticky,
   output logic [INT_W-1:0]  res,
   output logic              invalid,
   output logic              inexact
);
   localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

   logic [INT_W-1:0] sat;
   logic             ovf;

   assign sat = sign ? NEG_MIN : POS_MAX;
   assign ovf = too_big | (~sign & mag[INT_W-1]) | (sign & (mag > NEG_MIN));

   always_comb begin
      res     = '0;
      invalid = 1'b0;
      inexact = 1'b0;
      unique case (cls)
         CLS_ZERO: ;
         CLS_SUBN: inexact = 1'b1;
         CLS_NAN:  invalid = 1'b1;
         CLS_INF: begin
            invalid = 1'b1;
            res     = sat;
         end
         CLS_NORM: begin
            if (below_one) begin
               inexact = 1'b1;
            end else if (ovf) begin
               invalid = 1'b1;
               res     = sat;
            end else begin
               res     = sign ? (~mag + 1'b1) : mag;
               inexact = sticky;
            end
         end
         default: invalid = 1'b1;
      endcase
   end
endmodule

// File: rtl/dtoi_conv.sv
module dtoi_conv
   import dtoi_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [EXP_W+FRAC_W:0]       in_bits,
   output logic                        out_valid,
   output logic [INT_W-1:0]            out_int,
   output logic                        out_invalid,
   output logic                        out_inexact
);
   localparam int DW = 1 + EXP_W + FRAC_W;

   if (FRAC_W < INT_W) begin : g_bad_frac
      $error("dtoi_conv: FRAC_W must be at least INT_W");
   end
   if (((1 << (EXP_W-1)) - 1) < INT_W) begin : g_bad_exp
      $error("dtoi_conv: exponent range too small for INT_W");
   end
   if (INT_W < 2) begin : g_bad_int
      $error("dtoi_conv: INT_W must be at least 2");
   end

   logic                     sgn;
   logic [EXP_W-1:0]         exp_f;
   logic [FRAC_W-1:0]        frac_f;
   dtoi_cls_e                cls;
   logic signed [EXP_W:0]    unb_exp;
   logic [INT_W-1:0]         mag;
   logic                     too_big;
   logic                     below_one;
   logic                     sticky;
   logic [INT_W-1:0]         res;
   logic                     inv_c;
   logic                     inx_c;

   assign sgn    = in_bits[DW-1];
   assign exp_f  = in_bits[DW-2 -: EXP_W];
   assign frac_f = in_bits[FRAC_W-1:0];

   dtoi_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .exp_f   (exp_f),
      .frac_f  (frac_f),
      .cls     (cls),
      .unb_exp (unb_exp)
   );

   dtoi_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
      .frac_f    (frac_f),
      .unb_exp   (unb_exp),
      .mag       (mag),
      .too_big   (too_big),
      .below_one (below_one),
      .sticky    (sticky)
   );

   dtoi_range #(.INT_W(INT_W)) u_range (
      .sign      (sgn),
      .cls       (cls),
      .mag       (mag),
      .too_big   (too_big),
      .below_one (below_one),
      .sticky    (sticky),
      .res       (res),
      .invalid   (inv_c),
      .inexact   (inx_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_int     <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_int     <= res;
            out_invalid <= inv_c;
            out_inexact <= inx_c;
         end
      end
   end
endmodule

// File: rtl/dtoi_conv_chk.sv
module dtoi_conv_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int INT_W  = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [EXP_W+FRAC_W:0] in_bits,
   input logic                  out_valid,
   input logic [INT_W-1:0]      out_int,
   input logic                  out_invalid,
   input logic                  out_inexact
);
   localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

   logic             s_b;
   logic [EXP_W-1:0] e_b;
   logic             f_nz;

   assign s_b  = in_bits[EXP_W+FRAC_W];
   assign e_b  = in_bits[EXP_W+FRAC_W-1 -: EXP_W];
   assign f_nz = |in_bits[FRAC_W-1:0];

   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_int) && $stable(out_invalid) && $stable(out_inexact)));
   assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && e_b == '0 && !f_nz) |=> (out_int == '0 && !out_invalid && !out_inexact));
   assert_subnormal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && e_b == '0 && f_nz) |=> (out_int == '0 && out_inexact && !out_invalid));
   assert_pos_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !s_b) |=> !out_int[INT_W-1]);
   assert_infinity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && &e_b && !f_nz) |=> (out_invalid && out_int == (s_b ? NEG_MIN : POS_MAX)));
   assert_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && &e_b && f_nz) |=> (out_invalid && out_int == '0));
   assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_invalid && out_inexact));
   assert_reset_R11: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_int == '0 && !out_invalid && !out_inexact));
endmodule

bind dtoi_conv dtoi_conv_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_bits     (in_bits),
   .out_valid   (out_valid),
   .out_int     (out_int),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact)
);

// File: tb/test_dtoi_conv.sv
`timescale 1ns/1ps
module test_dtoi_conv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_bits = '0;
   logic        out_valid;
   logic [15:0] out_int;
   logic        out_invalid;
   logic        out_inexact;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   dtoi_conv i_dtoi_conv (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_bits     (in_bits),
      .out_valid   (out_valid),
      .out_int     (out_int),
      .out_invalid (out_invalid),
      .out_inexact (out_inexact)
   );

   task automatic check_out(input string tag, input logic ev,
                            input logic signed [15:0] ei, input logic einv, input logic einx);
      n_checks++;
      if (out_valid !== ev || out_int !== ei || out_invalid !== einv || out_inexact !== einx) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b int=%0d inv=%0b inx=%0b, want valid=%0b int=%0d inv=%0b inx=%0b",
                  tag, out_valid, $signed(out_int), out_invalid, out_inexact, ev, ei, einv, einx);
      end
   endtask

   task automatic apply(input string tag, input logic [63:0] bits,
                        input logic signed [15:0] ei, input logic einv, input logic einx);
      @(negedge clk);
      in_bits  = bits;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_out(tag, 1'b1, ei, einv, einx);
   endtask

   task automatic t_reset;
      in_valid = 1'b1;
      in_bits  = $realtobits(5.0);
      repeat (3) @(negedge clk);
      check_out("R11 outputs during reset", 1'b0, 16'sd0, 1'b0, 1'b0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      check_out("R11 idle after reset", 1'b0, 16'sd0, 1'b0, 1'b0);
   endtask

   task automatic t_zeros;
      apply("R2 +0", 64'h0000_0000_0000_0000, 16'sd0, 1'b0, 1'b0);
      apply("R2 -0", 64'h8000_0000_0000_0000, 16'sd0, 1'b0, 1'b0);
   endtask

   task automatic t_subnormal;
      apply("R3 tiny subnormal", 64'h0000_0000_0000_0001, 16'sd0, 1'b0, 1'b1);
      apply("R3 neg subnormal",  64'h800F_FFFF_FFFF_FFFF, 16'sd0, 1'b0, 1'b1);
   endtask

   task automatic t_fraction;
      apply("R4 0.75",           $realtobits(0.75), 16'sd0, 1'b0, 1'b1);
      apply("R4 -0.5",           $realtobits(-0.5), 16'sd0, 1'b0, 1'b1);
      apply("R4 smallest normal", 64'h0010_0000_0000_0000, 16'sd0, 1'b0, 1'b1);
   endtask

   task automatic t_in_range;
      apply("R5 1.0",       $realtobits(1.0),       16'sd1,     1'b0, 1'b0);
      apply("R5 -1.0",      $realtobits(-1.0),      -16'sd1,    1'b0, 1'b0);
      apply("R5 3.0",       $realtobits(3.0),       16'sd3,     1'b0, 1'b0);
      apply("R5 2.5",       $realtobits(2.5),       16'sd2,     1'b0, 1'b1);
      apply("R5 -2.5",      $realtobits(-2.5),      -16'sd2,    1'b0, 1'b1);
      apply("R5 12345.678", $realtobits(12345.678), 16'sd12345, 1'b0, 1'b1);
      apply("R5 32767.0",   $realtobits(32767.0),   16'sd32767, 1'b0, 1'b0);
      apply("R5 32767.9",   $realtobits(32767.9),   16'sd32767, 1'b0, 1'b1);
   endtask

   task automatic t_positive_ovf;
      apply("R6 32768.0", $realtobits(32768.0), 16'sd32767, 1'b1, 1'b0);
      apply("R6 65535.5", $realtobits(65535.5), 16'sd32767, 1'b1, 1'b0);
      apply("R6 1e10",    $realtobits(1.0e10),  16'sd32767, 1'b1, 1'b0);
   endtask

   task automatic t_negative_edge;
      apply("R7 -32768.0", $realtobits(-32768.0), -16'sd32768, 1'b0, 1'b0);
      apply("R7 -32768.5", $realtobits(-32768.5), -16'sd32768, 1'b0, 1'b1);
      apply("R7 -32769.0", $realtobits(-32769.0), -16'sd32768, 1'b1, 1'b0);
      apply("R7 -1e300",   $realtobits(-1.0e300), -16'sd32768, 1'b1, 1'b0);
   endtask

   task automatic t_infinity;
      apply("R8 +inf", 64'h7FF0_0000_0000_0000, 16'sd32767,  1'b1, 1'b0);
      apply("R8 -inf", 64'hFFF0_0000_0000_0000, -16'sd32768, 1'b1, 1'b0);
   endtask

   task automatic t_nan;
      apply("R9 quiet nan",     64'h7FF8_0000_0000_0000, 16'sd0, 1'b1, 1'b0);
      apply("R9 signaling nan", 64'h7FF0_0000_0000_0001, 16'sd0, 1'b1, 1'b0);
      apply("R9 negative nan",  64'hFFFF_FFFF_FFFF_FFFF, 16'sd0, 1'b1, 1'b0);
   endtask

   task automatic t_hold;
      apply("R1 load 7.25", $realtobits(7.25), 16'sd7, 1'b0, 1'b1);
      in_bits = 64'h7FF8_0000_0000_0000;
      @(negedge clk);
      check_out("R1 hold with strobe low", 1'b0, 16'sd7, 1'b0, 1'b1);
      in_bits = $realtobits(-100.0);
      @(negedge clk);
      check_out("R1 still holding", 1'b0, 16'sd7, 1'b0, 1'b1);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      in_valid = 1'b1;
      in_bits  = $realtobits(-9.0);
      @(negedge clk);
      check_out("R1 stream first", 1'b1, -16'sd9, 1'b0, 1'b0);
      in_bits = $realtobits(40000.0);
      @(negedge clk);
      check_out("R10 stream second", 1'b1, 16'sd32767, 1'b1, 1'b0);
      in_valid = 1'b0;
      @(negedge clk);
      check_out("R1 stream end", 1'b0, 16'sd32767, 1'b1, 1'b0);
   endtask

   initial begin
      t_reset();
      t_zeros();
      t_subnormal();
      t_fraction();
      t_in_range();
      t_positive_ovf();
      t_negative_edge();
      t_infinity();
      t_nan();
      t_hold();
      t_back_to_back();
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, want completion within 200000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule